// File: doc/BRIEF.md
# Raster Sync and Blanking Timing Generator

This block produces the line and frame timing for a raster display: horizontal and vertical sync, horizontal and vertical blanking, a display-enable window, and a line-match flag. Its inputs are a set of timing registers that use the classic offset encodings found in VGA-compatible display controllers. Horizontal positions are counted in character clocks. Each character clock is eight pixel-clock-enable ticks. Vertical positions are counted in scan lines.

Software writes the timing fields through a simple write port into a pending copy. The whole pending copy becomes active in one step at the frame boundary. This means one frame always runs with a single consistent set of timing. Two polarity pins decide whether each sync output is active high or active low. The character and line counters are brought out so that the downstream pixel fetch can follow the beam.

Top module: `crtc_timing_gen`

## Requirements
- R1: A character clock advances once every 8 cycles with `pix_ce` high. The counter does not move while `pix_ce` is low. `char_cnt` runs from 0 up to the line-length field plus 4 and then returns to 0, so a line is the field value + 5 characters long.
- R2: `line_cnt` advances once at the end of each line. It runs from 0 up to the frame-height field plus 1 and then returns to 0, so a frame is the field value + 2 lines.
- R3: `disp_en` is high exactly when `char_cnt` is at or below the horizontal display-end field and `line_cnt` is at or below the vertical display-end field.
- R4: The internal horizontal sync state turns on when `char_cnt` takes the value of the hsync start field. It turns off when the low 5 bits of `char_cnt` take the value of the 5-bit hsync end field. If both match on the same character, turning on wins.
- R5: `hblank` turns on when `char_cnt` takes the value of the hblank start field. It turns off when the low 6 bits of `char_cnt` match the 6-bit hblank end field. If both match at once, turning on wins.
- R6: The internal vertical sync state changes only at line boundaries. It turns on when `line_cnt` takes the value of the vsync start field and turns off when the low 4 bits of `line_cnt` match the 4-bit vsync end field. If both match at once, turning on wins.
- R7: `vblank` turns on when `line_cnt` takes the value of the vblank start field. It turns off when the low 8 bits of `line_cnt` match the 8-bit vblank end field. If both match at once, turning on wins.
- R8: `hsync` equals the horizontal sync state XOR `hsync_neg`. `vsync` equals the vertical sync state XOR `vsync_neg`. A pin at 1 therefore gives an active-low output, and the output follows the pin in the same cycle.
- R9: `line_cmp_hit` is high when `line_cnt` equals the 11-bit line-compare field. It is never high when that field is all ones (2047).
- R10: A write with `wr_en` high stores `wr_data` into a pending field selected by `wr_addr`. The addresses are: 0 line length (9 bits), 1 h display end (9), 2 hblank start (9), 3 hblank end (6), 4 hsync start (9), 5 hsync end (5), 6 frame height (11), 7 v display end (11), 8 vblank start (11), 9 vblank end (8), 10 vsync start (11), 11 vsync end (4), 12 line compare (11). Addresses 13 to 15 are ignored. Pending fields become active only on the character clock that wraps both counters to 0. The start and end compares made on that same clock already use the new values.
- R11: While `rst_n` is low, both counters are 0, all active and pending fields are 0, and all sync and blank states are off, so each sync output equals its polarity pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel clock enable |
| hsync_neg | input | 1 | 1 makes hsync active low |
| vsync_neg | input | 1 | 1 makes vsync active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Field select |
| wr_data | input | 11 | Field value, low bits used |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| disp_en | output | 1 | Active display window |
| line_cmp_hit | output | 1 | Line counter equals line compare |
| char_cnt | output | 10 | Character counter |
| line_cnt | output | 12 | Line counter |

## Verification
The assertions rely on a few properties of the inputs. The reset is released away from the clock edge. The counters only see active fields that change at a frame wrap, which keeps each counter within its current wrap value. The sync and blank checks assume the start and end fields are written whole through the port, so the values compared on the previous character clock are the values observed. The stimulus drives every input on the falling edge. It writes fields either with `pix_ce` held low or at arbitrary points inside a frame, and it lets a reference model decide in which frame each write takes effect. The fields it writes include wrap values that make the masked end compares differ from a full-width compare.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

  localparam int unsigned HREG_W = 9;
  localparam int unsigned VREG_W = 11;
  localparam int unsigned HSE_W  = 5;
  localparam int unsigned HBE_W  = 6;
  localparam int unsigned VSE_W  = 4;
  localparam int unsigned VBE_W  = 8;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = VREG_W;
  localparam int unsigned DOT_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    FLD_HLEN   = 4'd0,
    FLD_HDEND  = 4'd1,
    FLD_HBSTA  = 4'd2,
    FLD_HBEND  = 4'd3,
    FLD_HSSTA  = 4'd4,
    FLD_HSEND  = 4'd5,
    FLD_VLEN   = 4'd6,
    FLD_VDEND  = 4'd7,
    FLD_VBSTA  = 4'd8,
    FLD_VBEND  = 4'd9,
    FLD_VSSTA  = 4'd10,
    FLD_VSEND  = 4'd11,
    FLD_LMATCH = 4'd12
  } crtc_fld_e;

  typedef struct packed {
    logic [HREG_W-1:0] hlen;
    logic [HREG_W-1:0] hdend;
    logic [HREG_W-1:0] hbsta;
    logic [HBE_W-1:0]  hbend;
    logic [HREG_W-1:0] hssta;
    logic [HSE_W-1:0]  hsend;
    logic [VREG_W-1:0] vlen;
    logic [VREG_W-1:0] vdend;
    logic [VREG_W-1:0] vbsta;
    logic [VBE_W-1:0]  vbend;
    logic [VREG_W-1:0] vssta;
    logic [VSE_W-1:0]  vsend;
    logic [VREG_W-1:0] lmatch;
  } crtc_cfg_t;

endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_wrap,
  output crtc_cfg_t         cfg_act,
  output crtc_cfg_t         cfg_nxt
);

  crtc_cfg_t pend_q, pend_d;
  crtc_cfg_t act_q, act_d;

  // pending copy: field update from the write port
  always_comb begin
    pend_d = pend_q;
    if (wr_en) begin
      case (crtc_fld_e'(wr_addr))
        FLD_HLEN:   pend_d.hlen   = wr_data[HREG_W-1:0];
        FLD_HDEND:  pend_d.hdend  = wr_data[HREG_W-1:0];
        FLD_HBSTA:  pend_d.hbsta  = wr_data[HREG_W-1:0];
        FLD_HBEND:  pend_d.hbend  = wr_data[HBE_W-1:0];
        FLD_HSSTA:  pend_d.hssta  = wr_data[HREG_W-1:0];
        FLD_HSEND:  pend_d.hsend  = wr_data[HSE_W-1:0];
        FLD_VLEN:   pend_d.vlen   = wr_data[VREG_W-1:0];
        FLD_VDEND:  pend_d.vdend  = wr_data[VREG_W-1:0];
        FLD_VBSTA:  pend_d.vbsta  = wr_data[VREG_W-1:0];
        FLD_VBEND:  pend_d.vbend  = wr_data[VBE_W-1:0];
        FLD_VSSTA:  pend_d.vssta  = wr_data[VREG_W-1:0];
        FLD_VSEND:  pend_d.vsend  = wr_data[VSE_W-1:0];
        FLD_LMATCH: pend_d.lmatch = wr_data[VREG_W-1:0];
        default:    pend_d = pend_q;
      endcase
    end
  end

  // active copy: whole-set transfer at the frame boundary only
  always_comb begin
    act_d = act_q;
    if (frame_wrap) begin
      act_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign cfg_act = act_q;
  assign cfg_nxt = act_d;

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(act_q)); // R10

  AST_ACT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> act_q == $past(pend_q)); // R10

endmodule

// File: rtl/crtc_axis.sv
module crtc_axis #(
  parameter int unsigned REG_W    = 9,
  parameter int unsigned LAST_OFS = 4,
  parameter int unsigned SE_W     = 5,
  parameter int unsigned BE_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [REG_W-1:0] len,
  input  logic [REG_W-1:0] ssta,
  input  logic [SE_W-1:0]  send,
  input  logic [REG_W-1:0] bsta,
  input  logic [BE_W-1:0]  bend,
  output logic [REG_W:0]   cnt,
  output logic             at_last,
  output logic             sync_on,
  output logic             blank_on
);

  localparam int unsigned CNT_W = REG_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, last_val;
  logic             sync_q, sync_d;
  logic             blank_q, blank_d;

  assign last_val = CNT_W'(len) + CNT_W'(LAST_OFS);
  assign at_last  = (cnt_q == last_val);

  always_comb begin
    cnt_d   = cnt_q;
    sync_d  = sync_q;
    blank_d = blank_q;
    if (adv) begin
      cnt_d = at_last ? '0 : cnt_q + CNT_W'(1);
      if (cnt_d == CNT_W'(ssta)) begin
        sync_d = 1'b1;
      end else if (cnt_d[SE_W-1:0] == send) begin
        sync_d = 1'b0;
      end
      if (cnt_d == CNT_W'(bsta)) begin
        blank_d = 1'b1;
      end else if (cnt_d[BE_W-1:0] == bend) begin
        blank_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sync_q  <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sync_q  <= sync_d;
      blank_q <= blank_d;
    end
  end

  assign cnt      = cnt_q;
  assign sync_on  = sync_q;
  assign blank_on = blank_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_val); // R1 R2

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q)); // R1 R2

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && at_last |=> cnt_q == '0); // R1 R2

  AST_SYNC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> $past(adv) && cnt_q == CNT_W'($past(ssta))); // R4 R6

  AST_SYNC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_q) |-> $past(adv) && cnt_q[SE_W-1:0] == $past(send)); // R4 R6

  AST_BLANK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_q) |-> $past(adv) && cnt_q == CNT_W'($past(bsta))); // R5 R7

  AST_BLANK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank_q) |-> $past(adv) && cnt_q[BE_W-1:0] == $past(bend)); // R5 R7

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  logic              hsync_neg,
  input  logic              vsync_neg,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hsync,
  output logic              vsync,
  output logic              hblank,
  output logic              vblank,
  output logic              disp_en,
  output logic              line_cmp_hit,
  output logic [HREG_W:0]   char_cnt,
  output logic [VREG_W:0]   line_cnt
);

  localparam int unsigned H_CW = HREG_W + 1;
  localparam int unsigned V_CW = VREG_W + 1;

  logic [DOT_W-1:0] dot_q, dot_d;
  logic             char_tick, line_tick, frame_wrap;
  logic             h_last, v_last;
  logic             hs_on, vs_on;
  crtc_cfg_t        cfg_act, cfg_nxt;
  logic             unused_cfg;

  // pixel-within-character counter
  always_comb begin
    dot_d = dot_q;
    if (pix_ce) begin
      dot_d = dot_q + DOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q <= '0;
    end else begin
      dot_q <= dot_d;
    end
  end

  assign char_tick  = pix_ce && (&dot_q);
  assign line_tick  = char_tick && h_last;
  assign frame_wrap = line_tick && v_last;

  crtc_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .frame_wrap (frame_wrap),
    .cfg_act    (cfg_act),
    .cfg_nxt    (cfg_nxt)
  );

  crtc_axis #(
    .REG_W    (HREG_W),
    .LAST_OFS (4),
    .SE_W     (HSE_W),
    .BE_W     (HBE_W)
  ) u_haxis (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (char_tick),
    .len      (cfg_act.hlen),
    .ssta     (cfg_nxt.hssta),
    .send     (cfg_nxt.hsend),
    .bsta     (cfg_nxt.hbsta),
    .bend     (cfg_nxt.hbend),
    .cnt      (char_cnt),
    .at_last  (h_last),
    .sync_on  (hs_on),
    .blank_on (hblank)
  );

  crtc_axis #(
    .REG_W    (VREG_W),
    .LAST_OFS (1),
    .SE_W     (VSE_W),
    .BE_W     (VBE_W)
  ) u_vaxis (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (line_tick),
    .len      (cfg_act.vlen),
    .ssta     (cfg_nxt.vssta),
    .send     (cfg_nxt.vsend),
    .bsta     (cfg_nxt.vbsta),
    .bend     (cfg_nxt.vbend),
    .cnt      (line_cnt),
    .at_last  (v_last),
    .sync_on  (vs_on),
    .blank_on (vblank)
  );

  assign disp_en = (char_cnt <= H_CW'(cfg_act.hdend)) &&
                   (line_cnt <= V_CW'(cfg_act.vdend));

  assign line_cmp_hit = (line_cnt == V_CW'(cfg_act.lmatch)) && !(&cfg_act.lmatch);

  assign hsync = hs_on ^ hsync_neg;
  assign vsync = vs_on ^ vsync_neg;

  assign unused_cfg = ^{cfg_act.hbsta, cfg_act.hbend, cfg_act.hssta, cfg_act.hsend,
                        cfg_act.vbsta, cfg_act.vbend, cfg_act.vssta, cfg_act.vsend,
                        cfg_nxt.hlen, cfg_nxt.hdend, cfg_nxt.vlen, cfg_nxt.vdend,
                        cfg_nxt.lmatch};

  AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> char_cnt == '0 && line_cnt == '0); // R2

  AST_CHAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    char_tick && !h_last |=> char_cnt == $past(char_cnt) + H_CW'(1)); // R1

  AST_LINE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> $stable(line_cnt) && $stable(vs_on) && $stable(vblank)); // R6

  AST_DOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce |=> $stable(char_cnt) && $stable(line_cnt)); // R1

endmodule

// File: tb/crtc_timing_gen_tb.sv
module crtc_timing_gen_tb;
  import crtc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n, pix_ce, hneg, vneg, wr_en;
  logic [3:0]  wr_addr;
  logic [10:0] wr_data;
  logic        hsync, vsync, hblank, vblank, disp_en, line_cmp_hit;
  logic [9:0]  char_cnt;
  logic [11:0] line_cnt;

  int n_vec = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crtc_timing_gen u_dut (
    .clk (clk), .rst_n (rst_n), .pix_ce (pix_ce),
    .hsync_neg (hneg), .vsync_neg (vneg),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .hsync (hsync), .vsync (vsync), .hblank (hblank), .vblank (vblank),
    .disp_en (disp_en), .line_cmp_hit (line_cmp_hit),
    .char_cnt (char_cnt), .line_cnt (line_cnt)
  );

  // reference model built from the requirements
  logic [2:0]  m_dot;
  logic [9:0]  m_hc;
  logic [11:0] m_vc;
  logic        m_hs, m_hb, m_vs, m_vb;
  crtc_cfg_t   m_act, m_pend, m_nx;

  always @(posedge clk or negedge rst_n) begin : ref_model
    logic ct, lt, fw, hl, vl;
    logic [9:0]  hn;
    logic [11:0] vn;
    if (!rst_n) begin
      m_dot = '0; m_hc = '0; m_vc = '0;
      m_hs = 1'b0; m_hb = 1'b0; m_vs = 1'b0; m_vb = 1'b0;
      m_act = '0; m_pend = '0;
    end else begin
      hl = (m_hc == {1'b0, m_act.hlen} + 10'd4);
      vl = (m_vc == {1'b0, m_act.vlen} + 12'd1);
      ct = pix_ce && (m_dot == 3'd7);
      lt = ct && hl;
      fw = lt && vl;
      m_nx = fw ? m_pend : m_act;
      if (ct) begin
        hn = hl ? 10'd0 : m_hc + 10'd1;
        if (hn == {1'b0, m_nx.hssta}) m_hs = 1'b1;
        else if (hn[4:0] == m_nx.hsend) m_hs = 1'b0;
        if (hn == {1'b0, m_nx.hbsta}) m_hb = 1'b1;
        else if (hn[5:0] == m_nx.hbend) m_hb = 1'b0;
        m_hc = hn;
      end
      if (lt) begin
        vn = vl ? 12'd0 : m_vc + 12'd1;
        if (vn == {1'b0, m_nx.vssta}) m_vs = 1'b1;
        else if (vn[3:0] == m_nx.vsend) m_vs = 1'b0;
        if (vn == {1'b0, m_nx.vbsta}) m_vb = 1'b1;
        else if (vn[7:0] == m_nx.vbend) m_vb = 1'b0;
        m_vc = vn;
      end
      if (fw) m_act = m_pend;
      if (wr_en) begin
        case (wr_addr)
          4'd0:  m_pend.hlen   = wr_data[8:0];
          4'd1:  m_pend.hdend  = wr_data[8:0];
          4'd2:  m_pend.hbsta  = wr_data[8:0];
          4'd3:  m_pend.hbend  = wr_data[5:0];
          4'd4:  m_pend.hssta  = wr_data[8:0];
          4'd5:  m_pend.hsend  = wr_data[4:0];
          4'd6:  m_pend.vlen   = wr_data;
          4'd7:  m_pend.vdend  = wr_data;
          4'd8:  m_pend.vbsta  = wr_data;
          4'd9:  m_pend.vbend  = wr_data[7:0];
          4'd10: m_pend.vssta  = wr_data;
          4'd11: m_pend.vsend  = wr_data[3:0];
          4'd12: m_pend.lmatch = wr_data;
          default: ;
        endcase
      end
      if (pix_ce) m_dot = m_dot + 3'd1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, 3 ns after each rising edge
  always @(posedge clk) begin
    if (cmp_on) begin
      #3;
      chk(char_cnt == m_hc, "R1 char_cnt", char_cnt, m_hc);
      chk(line_cnt == m_vc, "R2 line_cnt", line_cnt, m_vc);
      chk(disp_en == ((m_hc <= {1'b0, m_act.hdend}) && (m_vc <= {1'b0, m_act.vdend})),
          "R3 disp_en", disp_en,
          int'((m_hc <= {1'b0, m_act.hdend}) && (m_vc <= {1'b0, m_act.vdend})));
      chk(hsync == (m_hs ^ hneg), "R4 hsync", hsync, m_hs ^ hneg);
      chk(hblank == m_hb, "R5 hblank", hblank, m_hb);
      chk(vsync == (m_vs ^ vneg), "R6 vsync", vsync, m_vs ^ vneg);
      chk(vblank == m_vb, "R7 vblank", vblank, m_vb);
      chk(line_cmp_hit == ((m_vc == {1'b0, m_act.lmatch}) && (m_act.lmatch != 11'h7ff)),
          "R9 line_cmp_hit", line_cmp_hit,
          int'((m_vc == {1'b0, m_act.lmatch}) && (m_act.lmatch != 11'h7ff)));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 11'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_mode(input int hl, input int hde, input int hbs, input int hbe,
                              input int hss, input int hse, input int vl, input int vde,
                              input int vbs, input int vbe, input int vss, input int vse,
                              input int lm);
    wr(0, hl);  wr(1, hde); wr(2, hbs);  wr(3, hbe); wr(4, hss); wr(5, hse);
    wr(6, vl);  wr(7, vde); wr(8, vbs);  wr(9, vbe); wr(10, vss); wr(11, vse);
    wr(12, lm);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pix_ce = 1'b0; hneg = 1'b0; vneg = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    run(3);
    #1;
    chk(char_cnt == 0, "R11 reset char_cnt", char_cnt, 0);
    chk(line_cnt == 0, "R11 reset line_cnt", line_cnt, 0);
    chk(hsync == 1'b0 && vsync == 1'b0, "R11 reset sync", {hsync, vsync}, 0);
    chk(hblank == 1'b0 && vblank == 1'b0, "R11 reset blank", {hblank, vblank}, 0);
    @(negedge clk);
    hneg = 1'b1; vneg = 1'b1;
    #1;
    chk(hsync == 1'b1 && vsync == 1'b1, "R11 reset sync follows pins", {hsync, vsync}, 3);
    @(negedge clk);
    hneg = 1'b0; vneg = 1'b0;
    rst_n = 1'b1;
    cmp_on = 1'b1;
  endtask

  // fields written while frozen; the first line still uses the reset timing
  task automatic t_deferred;
    int mx;
    pix_ce = 1'b0;
    program_mode(3, 4, 4, 7, 5, 6, 6, 3, 3, 7, 4, 5, 2);
    wr(15, 100);
    wr(13, 7);
    @(negedge clk);
    pix_ce = 1'b1;
    mx = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #3;
      if (line_cnt != 0) break;
      if (int'(char_cnt) > mx) mx = int'(char_cnt);
    end
    chk(mx == 4, "R10 old line length kept until frame end", mx, 4);
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #3;
      if (line_cnt == 0 && char_cnt == 0) break;
    end
    mx = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #3;
      if (line_cnt != 0) break;
      if (int'(char_cnt) > mx) mx = int'(char_cnt);
    end
    chk(mx == 7, "R10 new line length after frame wrap", mx, 7);
    for (int i = 0; i < 1200; i++) begin
      @(posedge clk); #3;
      if (line_cnt == 2) break;
    end
    chk(line_cmp_hit == 1'b1, "R9 hit on matching line", line_cmp_hit, 1);
    run(1100);
  endtask

  task automatic t_gaps;
    logic [9:0] held;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      pix_ce = (i % 3) != 0;
    end
    @(negedge clk);
    pix_ce = 1'b0;
    @(posedge clk); #3;
    held = char_cnt;
    run(6);
    #1;
    chk(char_cnt == held, "R1 counter frozen without pix_ce", char_cnt, held);
    @(negedge clk);
    pix_ce = 1'b1;
  endtask

  task automatic t_polarity;
    logic h0, v0;
    run(100);
    #1;
    h0 = hsync; v0 = vsync;
    hneg = 1'b1; vneg = 1'b1;
    #1;
    chk(hsync == ~h0, "R8 hsync follows pin", hsync, ~h0);
    chk(vsync == ~v0, "R8 vsync follows pin", vsync, ~v0);
    run(600);
    @(negedge clk);
    hneg = 1'b0;
    run(300);
    @(negedge clk);
    vneg = 1'b0;
  endtask

  // end values chosen so masked compares differ from full-width compares
  task automatic t_masked_ends;
    program_mode(70, 59, 60, 2, 62, 6, 20, 12, 12, 21, 14, 1, 16);
    run(30000);
  endtask

  task automatic t_lmatch_ones;
    program_mode(0, 2, 2, 4, 3, 4, 2046, 2000, 2000, 255, 2040, 12, 2047);
    for (int i = 0; i < 110000; i++) begin
      @(posedge clk); #3;
      if (line_cnt == 12'd2047) break;
    end
    chk(line_cnt == 12'd2047, "R9 reached line 2047", line_cnt, 2047);
    chk(line_cmp_hit == 1'b0, "R9 all-ones compare never matches", line_cmp_hit, 0);
    run(200);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_deferred();
    t_gaps();
    t_polarity();
    t_masked_ends();
    t_lmatch_ones();
    done = 1'b1;
    cmp_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule